// File: doc/BRIEF.md
# PCI Function Power State Controller

This block keeps the power state of a PCI network function and controls what the rest of the function may do in that state. Three states exist: full operation, an intermediate low-power state and a deepest low-power state. Software requests a new state by writing a two-bit power-state field. The block does not switch at once. It first asks every attached internal module to drain. It commits the new state only after each module has confirmed that it has nothing in flight.

The committed state drives the clock enables for three kinds of domain: the target (configuration) domain, the receive domain and the remaining functional domains. It also classifies incoming bus cycles. Outside full operation, only configuration cycles are accepted. Every other cycle is target-aborted, and the bus-master, memory-space and I/O-space command enables are forced to zero. In the intermediate state, a transfer request from the receive side raises a power management event when software has allowed this. The event stays raised until software clears its status bit.

Top module: `pci_pwr_mgr`

## Requirements
- R1: After a synchronous active-low reset, the readback state is 00 (D0), no change request is active, all clock enables are high and the PME output is low.
- R2: The power-state field is encoded 00=D0, 10=D2 and 11=D3. A write of a legal state that differs from the committed one raises `chg_req` on the next cycle, with `chg_target` holding the written code. During this time the readback keeps showing the old state.
- R3: A write of 01 (D1), or a write of the state already committed, is ignored: no request is raised and the state does not change.
- R4: The new state is committed only once every bit of `chg_ack` has been seen high since the request was raised (the bits may arrive in different cycles). The readback changes, and `chg_req` falls, on the cycle after the last acknowledge.
- R5: While a request is pending, further power-state writes are ignored and `chg_target` does not change.
- R6: In D0, the target, receive and all other clock enables are high.
- R7: In D2, only the target and receive clock enables are high. All other domain enables are low.
- R8: In D3, only the target clock enable is high.
- R9: In D0, every valid cycle is accepted. In D2 or D3, a valid configuration cycle is accepted and a valid non-configuration cycle is target-aborted.
- R10: In D0, the effective bus-master, memory and I/O enables follow the command bits. In D2 and D3 they are zero.
- R11: The PME status is set on the cycle after a receive request that arrives while the committed state is D2 and PME is enabled. A receive request has no effect in D0 or D3, or when PME is disabled.
- R12: Once set, the PME output stays high until a write-one-to-clear pulse on `pme_clr`. It then falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Function clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| ps_wr | input | 1 | Write strobe for the power-state field |
| ps_wdata | input | 2 | Written power-state code |
| ps_rdata | output | 2 | Committed power-state readback |
| chg_req | output | 1 | State-change request to all modules |
| chg_target | output | 2 | State being requested |
| chg_ack | input | N_MOD | Per-module drain acknowledge |
| clk_en_tgt | output | 1 | Target domain clock enable |
| clk_en_rx | output | 1 | Receive domain clock enable |
| clk_en_fn | output | N_DOM | Other domain clock enables |
| cyc_valid | input | 1 | A bus cycle addresses this function |
| cyc_is_cfg | input | 1 | That cycle is a configuration access |
| cyc_accept | output | 1 | Cycle accepted |
| cyc_abort | output | 1 | Cycle terminated with target abort |
| cmd_en | input | 3 | Command bits {master, memory, I/O} |
| cmd_en_eff | output | 3 | Effective command enables |
| rx_req | input | 1 | Transfer request from receive module |
| pme_en | input | 1 | PME generation enabled by software |
| pme_clr | input | 1 | Write-one-to-clear pulse for PME status |
| pme_out | output | 1 | Power management event (status) |

## Verification
The assertions assume that `chg_ack` bits are meaningful only while `chg_req` is high. They also assume that `pme_clr` is a pulse driven by a software write and not a level held during a wakeup. The stimulus raises each acknowledge only after a request is visible, drives it for exactly one cycle, and drives every input on the falling edge. Each scenario is built from a committed state, so every state-dependent output is checked with stable inputs.

// File: rtl/pwr_pkg.sv
// Package: shared power-state encoding for the power controller.
// Assumes: the 2-bit field code is also the software-visible encoding.
package pwr_pkg;
    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pwr_state_t;

    localparam int CMD_W = 3;

    // Return 1 for the codes this function supports.
    function automatic logic ps_legal(input logic [1:0] code);
        return code != PS_D1;
    endfunction
endpackage

// File: rtl/pwr_state_ctrl.sv
// Module: holds the committed power state and runs the drain handshake.
// Assumes: ack bits may pulse; they are remembered until all have been seen.
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int N_MOD = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ps_wr,
    input  logic [1:0]       ps_wdata,
    input  logic [N_MOD-1:0] chg_ack,
    output pwr_state_t       state,
    output logic             chg_req,
    output logic [1:0]       chg_target
);
    pwr_state_t       state_q;
    pwr_state_t       target_q;
    logic             pend_q;
    logic [N_MOD-1:0] seen_q;
    logic             all_ack;
    logic             start;

    // Purpose: decide whether a write starts a handshake, and whether all acks are in.
    always_comb begin
        all_ack = &(seen_q | chg_ack);
        start   = ps_wr && !pend_q && ps_legal(ps_wdata) && (ps_wdata != state_q);
    end

    // Purpose: state register, request tracking and ack accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PS_D0;
            target_q <= PS_D0;
            pend_q   <= 1'b0;
            seen_q   <= '0;
        end else if (pend_q) begin
            if (all_ack) begin
                state_q <= target_q;
                pend_q  <= 1'b0;
                seen_q  <= '0;
            end else begin
                seen_q  <= seen_q | chg_ack;
            end
        end else if (start) begin
            pend_q   <= 1'b1;
            target_q <= pwr_state_t'(ps_wdata);
        end
    end

    assign state      = state_q;
    assign chg_req    = pend_q;
    assign chg_target = target_q;

    AST_NO_D1_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != PS_D1);                                                  // R3
    AST_COMMIT_NEEDS_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !(&(seen_q | chg_ack))) |=> (state_q == $past(state_q)) && pend_q); // R4
    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !(&(seen_q | chg_ack))) |=> (target_q == $past(target_q))); // R5
    AST_IDLE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && ps_wr && (ps_wdata == state_q || ps_wdata == PS_D1)) |=> !pend_q); // R3
endmodule

// File: rtl/pwr_clk_gate.sv
// Module: derives the per-domain clock enables from the committed state.
// Assumes: the target domain always runs; N_DOM other domains share one policy.
module pwr_clk_gate
    import pwr_pkg::*;
#(
    parameter int N_DOM = 2
) (
    input  pwr_state_t       state,
    output logic             en_tgt,
    output logic             en_rx,
    output logic [N_DOM-1:0] en_fn
);
    // Purpose: the target domain is never gated.
    assign en_tgt = 1'b1;

    // Purpose: the receive domain runs unless the state is the deepest one.
    always_comb begin
        en_rx = (state != PS_D3);
    end

    // Purpose: each other functional domain runs only at full power.
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        assign en_fn[d] = (state == PS_D0);
    end
endmodule

// File: rtl/pwr_cyc_filter.sv
// Module: classifies bus cycles and masks the command enables by power state.
// Assumes: cyc_is_cfg is qualified by cyc_valid from the protocol engine.
module pwr_cyc_filter
    import pwr_pkg::*;
(
    input  pwr_state_t       state,
    input  logic             cyc_valid,
    input  logic             cyc_is_cfg,
    input  logic [CMD_W-1:0] cmd_en,
    output logic             cyc_accept,
    output logic             cyc_abort,
    output logic [CMD_W-1:0] cmd_en_eff
);
    logic full_pwr;

    // Purpose: accept or abort each cycle, and zero the enables outside full power.
    always_comb begin
        full_pwr   = (state == PS_D0);
        cyc_accept = cyc_valid && (full_pwr || cyc_is_cfg);
        cyc_abort  = cyc_valid && !full_pwr && !cyc_is_cfg;
        cmd_en_eff = full_pwr ? cmd_en : '0;
    end
endmodule

// File: rtl/pwr_pme_unit.sv
// Module: sticky power management event status raised by receive wakeups.
// Assumes: a set in the same cycle as a clear wins, so no wakeup is lost.
module pwr_pme_unit
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_t state,
    input  logic       rx_req,
    input  logic       pme_en,
    input  logic       pme_clr,
    output logic       pme_out
);
    logic sts_q;
    logic set_ev;

    // Purpose: a wakeup counts only in the intermediate state with PME enabled.
    always_comb begin
        set_ev = rx_req && pme_en && (state == PS_D2);
    end

    // Purpose: hold the status until software writes one to clear it.
    always_ff @(posedge clk) begin
        if (!rst_n)       sts_q <= 1'b0;
        else if (set_ev)  sts_q <= 1'b1;
        else if (pme_clr) sts_q <= 1'b0;
    end

    assign pme_out = sts_q;

    AST_PME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !pme_clr) |=> sts_q);                                     // R12
    AST_PME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_q && !(rx_req && pme_en)) |=> !sts_q);                        // R11
endmodule

// File: rtl/pci_pwr_mgr.sv
// Module: top of the PCI function power manager.
// Assumes: configuration registers, protocol engine and receive path sit outside
// and talk to this block through plain strobes and levels.
module pci_pwr_mgr
    import pwr_pkg::*;
#(
    parameter int N_MOD = 3,
    parameter int N_DOM = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ps_wr,
    input  logic [1:0]       ps_wdata,
    output logic [1:0]       ps_rdata,
    output logic             chg_req,
    output logic [1:0]       chg_target,
    input  logic [N_MOD-1:0] chg_ack,
    output logic             clk_en_tgt,
    output logic             clk_en_rx,
    output logic [N_DOM-1:0] clk_en_fn,
    input  logic             cyc_valid,
    input  logic             cyc_is_cfg,
    output logic             cyc_accept,
    output logic             cyc_abort,
    input  logic [2:0]       cmd_en,
    output logic [2:0]       cmd_en_eff,
    input  logic             rx_req,
    input  logic             pme_en,
    input  logic             pme_clr,
    output logic             pme_out
);
    pwr_state_t state;

    pwr_state_ctrl #(.N_MOD(N_MOD)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps_wr      (ps_wr),
        .ps_wdata   (ps_wdata),
        .chg_ack    (chg_ack),
        .state      (state),
        .chg_req    (chg_req),
        .chg_target (chg_target)
    );

    pwr_clk_gate #(.N_DOM(N_DOM)) u_gate (
        .state  (state),
        .en_tgt (clk_en_tgt),
        .en_rx  (clk_en_rx),
        .en_fn  (clk_en_fn)
    );

    pwr_cyc_filter u_filt (
        .state      (state),
        .cyc_valid  (cyc_valid),
        .cyc_is_cfg (cyc_is_cfg),
        .cmd_en     (cmd_en),
        .cyc_accept (cyc_accept),
        .cyc_abort  (cyc_abort),
        .cmd_en_eff (cmd_en_eff)
    );

    pwr_pme_unit u_pme (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .rx_req  (rx_req),
        .pme_en  (pme_en),
        .pme_clr (pme_clr),
        .pme_out (pme_out)
    );

    assign ps_rdata = state;

    AST_ABORT_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_is_cfg && !clk_en_fn[0]) |-> cyc_abort);         // R9
    AST_MASK_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_fn[0] |-> (cmd_en_eff == 3'b000));                          // R10
    AST_PME_NEEDS_RX_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pme_out) |-> $past(clk_en_rx && !clk_en_fn[0]));              // R11
endmodule

// File: tb/pci_pwr_mgr_test.sv
module pci_pwr_mgr_test;
    localparam int N_MOD = 3;
    localparam int N_DOM = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ps_wr = 1'b0;
    logic [1:0] ps_wdata = 2'b00;
    logic [1:0] ps_rdata;
    logic chg_req;
    logic [1:0] chg_target;
    logic [N_MOD-1:0] chg_ack = '0;
    logic clk_en_tgt, clk_en_rx;
    logic [N_DOM-1:0] clk_en_fn;
    logic cyc_valid = 1'b0, cyc_is_cfg = 1'b0;
    logic cyc_accept, cyc_abort;
    logic [2:0] cmd_en = 3'b000;
    logic [2:0] cmd_en_eff;
    logic rx_req = 1'b0, pme_en = 1'b0, pme_clr = 1'b0;
    logic pme_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        int         sel;
        logic [7:0] exp;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    pci_pwr_mgr #(.N_MOD(N_MOD), .N_DOM(N_DOM)) uut (.*);

    // Read one observable output group; sel picks which.
    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return {6'b0, ps_rdata};
            1: return {7'b0, chg_req};
            2: return {6'b0, chg_target};
            3: return {5'b0, clk_en_tgt, clk_en_rx, &clk_en_fn | (|clk_en_fn) & 1'b0 | (&clk_en_fn)};
            4: return {6'b0, cyc_accept, cyc_abort};
            5: return {5'b0, cmd_en_eff};
            6: return {7'b0, pme_out};
            default: return 8'hxx;
        endcase
    endfunction

    // Driver side: queue an expectation for the edge that follows.
    task automatic expect_q(string tag, int sel, logic [7:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb.push_back(it);
    endtask

    // Monitor: after each rising edge, pop and compare every queued item.
    always @(posedge clk) begin
        #2;
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        cyc_valid = 1'b1; cyc_is_cfg = 1'b0; cmd_en = 3'b101;
        // R1 reset state
        expect_q("R1", 0, 8'h00); expect_q("R1", 1, 8'h00);
        expect_q("R1", 3, 8'h07); expect_q("R1", 6, 8'h00);
        expect_q("R6", 3, 8'h07); expect_q("R9", 4, 8'h02);
        expect_q("R10", 5, 8'h05);
        tick();
        // R3 write of D1 ignored
        ps_wr = 1'b1; ps_wdata = 2'b01;
        expect_q("R3", 1, 8'h00); expect_q("R3", 0, 8'h00);
        tick();
        // R3 write of current state ignored
        ps_wdata = 2'b00;
        expect_q("R3", 1, 8'h00);
        tick();
        // R11 receive request in D0 has no effect
        ps_wr = 1'b0; rx_req = 1'b1; pme_en = 1'b1;
        expect_q("R11", 6, 8'h00);
        tick();
        rx_req = 1'b0;
        // R2 request to D2
        ps_wr = 1'b1; ps_wdata = 2'b10;
        expect_q("R2", 1, 8'h01); expect_q("R2", 2, 8'h02); expect_q("R2", 0, 8'h00);
        tick();
        // R5 write while pending ignored
        ps_wdata = 2'b11;
        expect_q("R5", 2, 8'h02); expect_q("R5", 1, 8'h01);
        tick();
        ps_wr = 1'b0;
        // R4 staggered acknowledges
        chg_ack = 3'b001;
        expect_q("R4", 0, 8'h00); expect_q("R4", 1, 8'h01);
        expect_q("R6", 3, 8'h07);
        tick();
        chg_ack = 3'b100;
        expect_q("R4", 0, 8'h00);
        tick();
        chg_ack = 3'b010;
        expect_q("R4", 0, 8'h02); expect_q("R4", 1, 8'h00);
        tick();
        chg_ack = 3'b000;
        // R7 clocks, R9 abort, R10 masking in D2
        cmd_en = 3'b111;
        expect_q("R7", 3, 8'h06); expect_q("R9", 4, 8'h01);
        expect_q("R10", 5, 8'h00);
        tick();
        cyc_is_cfg = 1'b1;
        expect_q("R9", 4, 8'h02);
        tick();
        // R11 disabled PME: no effect
        pme_en = 1'b0; rx_req = 1'b1;
        expect_q("R11", 6, 8'h00);
        tick();
        // R11 enabled PME: set next cycle
        pme_en = 1'b1;
        expect_q("R11", 6, 8'h01);
        tick();
        rx_req = 1'b0;
        expect_q("R12", 6, 8'h01);
        tick();
        expect_q("R12", 6, 8'h01);
        tick();
        pme_clr = 1'b1;
        expect_q("R12", 6, 8'h00);
        tick();
        pme_clr = 1'b0;
        // go to D3 with all acks at once
        ps_wr = 1'b1; ps_wdata = 2'b11;
        expect_q("R2", 2, 8'h03); expect_q("R2", 0, 8'h02);
        tick();
        ps_wr = 1'b0; chg_ack = 3'b111;
        expect_q("R4", 0, 8'h03); expect_q("R4", 1, 8'h00);
        tick();
        chg_ack = 3'b000; cyc_is_cfg = 1'b0; rx_req = 1'b1;
        expect_q("R8", 3, 8'h04); expect_q("R9", 4, 8'h01);
        expect_q("R10", 5, 8'h00);
        tick();
        // R11 receive request in D3 has no effect
        expect_q("R11", 6, 8'h00);
        tick();
        rx_req = 1'b0;
        // back to D0
        ps_wr = 1'b1; ps_wdata = 2'b00;
        expect_q("R2", 1, 8'h01);
        tick();
        ps_wr = 1'b0; chg_ack = 3'b111;
        expect_q("R4", 0, 8'h00);
        tick();
        chg_ack = 3'b000; cmd_en = 3'b010;
        expect_q("R6", 3, 8'h07); expect_q("R10", 5, 8'h02);
        expect_q("R9", 4, 8'h02);
        tick();
        // R1 reset from a low-power state: enter D2 then reset
        ps_wr = 1'b1; ps_wdata = 2'b10;
        tick();
        ps_wr = 1'b0; chg_ack = 3'b111;
        expect_q("R4", 0, 8'h02);
        tick();
        chg_ack = 3'b000; rst_n = 1'b0;
        expect_q("R1", 0, 8'h00); expect_q("R1", 3, 8'h07);
        tick();
        rst_n = 1'b1;
        tick(); tick();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule